// File: doc/BRIEF.md
# Bit Error Rate Counter

This block measures transmission errors on one channel of a serial time-division stream while a bit error rate test runs. Each time a channel byte is marked valid and the test is enabled, the received byte is compared with the byte the pattern source expected, and every bit that differs adds one to an internal running total. A received byte of all ones is treated as an idle line and never contributes, whatever the expected byte was.

The running total is not visible to the host while the test runs. When the test enable drops, the total is frozen and copied into a host-facing result register, which the host can only read. A low-to-high change on a clear control bit wipes both the running total and the result register. Holding the clear bit high wipes them only once. The running total saturates at its all-ones value rather than wrapping.

Top module: `ber_counter`

## Requirements
- R1: After a clock edge with `rst_n` low, `err_count` reads 0 and the running total is 0.
- R2: On each clock edge where `test_en` and `byte_valid` are both high and `rx_byte` is not 8'hFF, the running total grows by the number of bit positions in which `rx_byte` and `exp_byte` differ (0 to 8).
- R3: A valid byte whose `rx_byte` equals 8'hFF leaves the running total unchanged, even when it differs from `exp_byte`.
- R4: On a clock edge where `test_en` is low and was high at the previous edge, and no clear is seen, `err_count` takes the running total value, visible one cycle later.
- R5: `err_count` changes only on a stop edge (R4) or a clear edge (R6); it is unchanged while the test runs.
- R6: On a clock edge where `clear_ctl` is high and was low at the previous edge, both the running total and `err_count` become 0. This has priority over accumulation and over a stop on the same edge. Keeping `clear_ctl` high afterwards does not clear again.
- R7: The running total saturates at 65535 (16 bits) and never wraps to a smaller value.
- R8: While `test_en` is low, valid bytes do not change the running total.
- R9: Bytes presented with `byte_valid` low do not change the running total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| test_en | input | 1 | High while the error rate test runs; falling level stops it |
| byte_valid | input | 1 | Marks the selected channel byte on `rx_byte`/`exp_byte` |
| rx_byte | input | 8 | Received channel byte |
| exp_byte | input | 8 | Expected pattern byte for the same channel |
| clear_ctl | input | 1 | Clear control bit; acts on its rising change |
| err_count | output | 16 | Latched error count, read-only to the host |

## Verification
The running total can only be seen through `err_count` after a stop. A wrong increment, a missed all-ones exemption or a wrap instead of saturation therefore shows up in the first result latched after the faulty byte. That is one cycle after `test_en` falls. A spurious change of the result register while the test runs, or a clear that fires on a held level, shows at the next sampled cycle. For this reason the bench compares `err_count` with its model on every cycle rather than only at the end of a run.

// File: rtl/ber_pkg.sv
// Package ber_pkg
// Shared types for the error rate counter. The command encoding orders
// the actions the running total and result register may take on an edge.
package ber_pkg;

    // One action per clock edge; the decoder resolves priority.
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,  // nothing changes
        CMD_ACCUM = 2'd1,  // add mismatch weight to running total
        CMD_LATCH = 2'd2,  // copy running total into result register
        CMD_CLEAR = 2'd3   // zero running total and result register
    } ber_cmd_e;

endpackage

// File: rtl/ber_ctrl.sv
// Module ber_ctrl
// Keeps one-cycle history of the test enable and the clear bit. From them it
// decodes the single action for this edge: clear beats latch, and latch beats
// accumulate. Assumes all inputs are synchronous to clk.
module ber_ctrl
    import ber_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     test_en,
    input  logic     byte_valid,
    input  logic     clear_ctl,
    output ber_cmd_e cmd
);

    logic en_q;
    logic clr_q;
    logic clr_rise;
    logic stop_seen;

    // Remember last-cycle enable and clear for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            en_q  <= test_en;
            clr_q <= clear_ctl;
        end
    end

    assign clr_rise  = clear_ctl & ~clr_q;
    assign stop_seen = en_q & ~test_en;

    // Resolve the per-edge action by fixed priority.
    always_comb begin
        if (clr_rise)                  cmd = CMD_CLEAR;
        else if (stop_seen)            cmd = CMD_LATCH;
        else if (test_en & byte_valid) cmd = CMD_ACCUM;
        else                           cmd = CMD_HOLD;
    end

endmodule

// File: rtl/ber_mismatch.sv
// Module ber_mismatch
// Counts the bit positions in which the received and expected bytes differ.
// A received word of all ones is an idle line and yields a weight of zero.
// Purely combinational; the caller decides whether the weight is used.
module ber_mismatch #(
    parameter int BYTE_W = 8,
    localparam int WT_W  = $clog2(BYTE_W + 1)
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] exp_byte,
    output logic [WT_W-1:0]   weight
);

    logic [BYTE_W-1:0] diff;
    logic              rx_idle;

    // Per-bit difference, one XOR per lane.
    for (genvar b = 0; b < BYTE_W; b++) begin : g_lane
        assign diff[b] = rx_byte[b] ^ exp_byte[b];
    end

    assign rx_idle = &rx_byte;

    // Population count of the difference, suppressed for idle data.
    always_comb begin
        weight = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            weight = weight + WT_W'(diff[i]);
        end
        if (rx_idle) weight = '0;
    end

endmodule

// File: rtl/ber_accum.sv
// Module ber_accum
// Running error total. Adds the byte weight on an accumulate command and
// clamps at the all-ones value. A clear command zeroes it; other commands
// hold it. Assumes the weight never exceeds the counter range in one step.
module ber_accum
    import ber_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ber_cmd_e         cmd,
    input  logic [WT_W-1:0]  weight,
    output logic [CNT_W-1:0] run_cnt
);

    localparam logic [CNT_W:0] SUM_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] sum;

    assign sum = {1'b0, run_cnt} + (CNT_W + 1)'(weight);

    // Update the running total according to the decoded command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else begin
            case (cmd)
                CMD_CLEAR: run_cnt <= '0;
                CMD_ACCUM: run_cnt <= (sum > SUM_MAX) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
                default:   run_cnt <= run_cnt;
            endcase
        end
    end

endmodule

// File: rtl/ber_counter.sv
// Module ber_counter
// Top of the error rate counter. It ties the control decoder, the mismatch
// weigher and the running total together and holds the host-visible result
// register. The result register loads only on a stop or a clear. Assumes
// channel selection and pattern generation happen upstream.
module ber_counter
    import ber_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] exp_byte,
    input  logic              clear_ctl,
    output logic [CNT_W-1:0]  err_count
);

    localparam int WT_W = $clog2(BYTE_W + 1);

    ber_cmd_e         cmd;
    logic [WT_W-1:0]  weight;
    logic [CNT_W-1:0] run_cnt;

    ber_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (test_en),
        .byte_valid (byte_valid),
        .clear_ctl  (clear_ctl),
        .cmd        (cmd)
    );

    ber_mismatch #(.BYTE_W(BYTE_W)) u_mismatch (
        .rx_byte  (rx_byte),
        .exp_byte (exp_byte),
        .weight   (weight)
    );

    ber_accum #(.CNT_W(CNT_W), .WT_W(WT_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .weight  (weight),
        .run_cnt (run_cnt)
    );

    // Result register: freeze the running total on stop, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_count <= '0;
        end else begin
            case (cmd)
                CMD_CLEAR: err_count <= '0;
                CMD_LATCH: err_count <= run_cnt;
                default:   err_count <= err_count;
            endcase
        end
    end

endmodule

// File: rtl/ber_counter_checker.sv
// Module ber_counter_checker
// Property checks for ber_counter, attached by bind. Keeps its own copy of
// the previous enable and clear levels so that the edges are derived from the
// ports, independently of the decoder.
module ber_counter_checker #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_en,
    input logic              byte_valid,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              clear_ctl,
    input logic [CNT_W-1:0]  err_count,
    input logic [CNT_W-1:0]  run_cnt
);

    logic c_en_q;
    logic c_clr_q;
    logic c_clr_rise;
    logic c_stop;

    // Port-level history of enable and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_en_q  <= 1'b0;
            c_clr_q <= 1'b0;
        end else begin
            c_en_q  <= test_en;
            c_clr_q <= clear_ctl;
        end
    end

    assign c_clr_rise = clear_ctl & ~c_clr_q;
    assign c_stop     = c_en_q & ~test_en;

    // R1: the first cycle out of reset shows a zero result.
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (err_count == '0 && run_cnt == '0));

    // R3: idle (all ones) data never grows the total.
    a_r3_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && byte_valid && (&rx_byte) && !c_clr_rise) |=> $stable(run_cnt));

    // R4: a stop copies the running total into the result.
    a_r4_stop_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (c_stop && !c_clr_rise) |=> (err_count == $past(run_cnt)));

    // R5: outside stop and clear the result register is steady.
    a_r5_result_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_stop && !c_clr_rise) |=> $stable(err_count));

    // R6: a rising clear zeroes both counters.
    a_r6_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr_rise |=> (err_count == '0 && run_cnt == '0));

    // R7: a full total stays full until cleared.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((&run_cnt) && !c_clr_rise) |=> (&run_cnt));

    // R8: a disabled test holds the running total.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && !c_clr_rise) |=> $stable(run_cnt));

    // R9: bytes not marked valid are not counted.
    a_r9_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && !c_clr_rise) |=> $stable(run_cnt));

endmodule

bind ber_counter ber_counter_checker #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (test_en),
    .byte_valid (byte_valid),
    .rx_byte    (rx_byte),
    .clear_ctl  (clear_ctl),
    .err_count  (err_count),
    .run_cnt    (run_cnt)
);

// File: tb/ber_counter_bench.sv
module ber_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        test_en;
    logic        byte_valid;
    logic [7:0]  rx_byte;
    logic [7:0]  exp_byte;
    logic        clear_ctl;
    logic [15:0] err_count;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    // Reference state kept by the bench.
    int unsigned m_run = 0;
    int unsigned m_cnt = 0;
    bit          m_en_q = 0;
    bit          m_clr_q = 0;

    always #4 clk = ~clk;

    ber_counter u_ber_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (test_en),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .exp_byte   (exp_byte),
        .clear_ctl  (clear_ctl),
        .err_count  (err_count)
    );

    function automatic int unsigned popc8(input logic [7:0] v);
        int unsigned n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return n;
    endfunction

    function automatic int unsigned sat16(input int unsigned v);
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic check(input string tag, input int unsigned exp_v);
        n_vec++;
        if (err_count !== exp_v[15:0]) begin
            n_fail++;
            $display("FAIL %s: err_count=%0d expected=%0d at t=%0t", tag, err_count, exp_v, $time);
        end
    endtask

    // Drive one cycle, advance the model, sample at the following negedge.
    task automatic step(input bit en, input bit v, input logic [7:0] rx,
                        input logic [7:0] ex, input bit clr, input string tag);
        bit rise, stop;
        test_en = en; byte_valid = v; rx_byte = rx; exp_byte = ex; clear_ctl = clr;
        rise = clr && !m_clr_q;
        stop = m_en_q && !en;
        if (rise) begin
            m_run = 0; m_cnt = 0;
        end else begin
            if (stop) m_cnt = m_run;
            if (en && v && rx != 8'hFF) m_run = sat16(m_run + popc8(rx ^ ex));
        end
        m_en_q = en; m_clr_q = clr;
        @(posedge clk);
        @(negedge clk);
        check(tag, m_cnt);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected<=190000", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; test_en = 1'b1; byte_valid = 1'b1;
        rx_byte = 8'h00; exp_byte = 8'hFF; clear_ctl = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset cleared everything despite active mismatching inputs.
        check("R1", 0);
        test_en = 1'b0; byte_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 8'h00, 8'h00, 0, "R1");

        // R2: two valid bytes (3 and 8 mismatches), count steady while running (R5).
        step(1, 1, 8'b0000_0111, 8'h00, 0, "R5");
        step(1, 1, 8'h00, 8'hFF, 0, "R5");
        step(1, 0, 8'h00, 8'hFF, 0, "R9");
        step(0, 0, 8'h00, 8'h00, 0, "R4");   // stop: expect 11
        step(0, 0, 8'h00, 8'h00, 0, "R2");

        // R3: all-ones received against zero expectation.
        step(0, 0, 8'h00, 8'h00, 1, "R6");
        step(1, 1, 8'hFF, 8'h00, 0, "R3");
        step(1, 1, 8'hFF, 8'h0F, 0, "R3");
        step(1, 1, 8'hFE, 8'hFF, 0, "R3");   // one counted error
        step(0, 0, 8'h00, 8'h00, 0, "R3");   // expect 1

        // R8: disabled test ignores valid mismatching bytes; R9 invalid ignored.
        step(0, 1, 8'h00, 8'hFF, 0, "R8");
        step(0, 1, 8'h00, 8'hFF, 0, "R8");
        step(1, 0, 8'h00, 8'hFF, 0, "R9");
        step(0, 0, 8'h00, 8'h00, 0, "R8");   // still 1

        // R6: clear held high clears once; counting continues under it.
        step(0, 0, 8'h00, 8'h00, 0, "R6");
        step(1, 1, 8'h00, 8'h03, 1, "R6");   // clear wins over accumulate
        step(1, 1, 8'h00, 8'h03, 1, "R6");   // +2
        step(1, 1, 8'h00, 8'h01, 1, "R6");   // +1
        step(0, 0, 8'h00, 8'h00, 1, "R6");   // stop, expect 3
        step(0, 0, 8'h00, 8'h00, 0, "R6");
        // Clear coinciding with a stop: clear has priority.
        step(1, 1, 8'h00, 8'hFF, 0, "R6");
        step(0, 0, 8'h00, 8'h00, 1, "R6");
        step(0, 0, 8'h00, 8'h00, 0, "R6");

        // R7: saturation at 65535.
        step(0, 0, 8'h00, 8'h00, 0, "R7");
        step(0, 0, 8'h00, 8'h00, 1, "R7");
        for (int i = 0; i < 8200; i++) step(1, 1, 8'h00, 8'hFF, 0, "R7");
        step(0, 0, 8'h00, 8'h00, 0, "R7");   // expect 65535
        step(1, 1, 8'h00, 8'hFF, 0, "R7");
        step(0, 0, 8'h00, 8'h00, 0, "R7");   // still 65535

        // R2: constrained random mix with a fixed seed.
        begin
            int unsigned seed_dummy;
            bit en_r;
            seed_dummy = $urandom(32'h5eed_1234);
            en_r = 0;
            for (int i = 0; i < 3000; i++) begin
                logic [7:0] rx, ex;
                bit v, clr;
                if ($urandom_range(15) == 0) en_r = !en_r;
                v   = ($urandom_range(3) != 0);
                rx  = ($urandom_range(7) == 0) ? 8'hFF : 8'($urandom);
                ex  = 8'($urandom);
                clr = ($urandom_range(31) == 0);
                step(en_r, v, rx, ex, clr, "R2");
            end
            step(0, 0, 8'h00, 8'h00, 0, "R4");
        end

        finish_run();
    end

endmodule